// File: doc/BRIEF.md
# Fence-Ordered Store Buffer

This block sits between a core's store pipeline and a single memory write port. Stores come in over a valid/ready channel and are held in a small queue. A front-end decoder looks at three opcode bytes and may insert an ordering barrier into that queue. Every barrier opens a new epoch. Epochs leave the queue strictly in turn. A store from a later epoch is not sent to memory until every store from earlier epochs has been acknowledged. Inside one epoch, stores issue back to back. A store that hits the same 8-byte word as the youngest waiting entry is folded into that entry.

Loads probe the queue at any time and are never held back by a barrier. The youngest buffered byte wins for each byte lane. A lookup that cannot cover every requested byte reports a miss, so the read goes to memory instead. Illegal barrier encodings raise an invalid-opcode fault and leave the queue unchanged. A status output shows when no store older than the latest barrier is still waiting for its acknowledge.

Top module: `sbf_store_buffer`

## Requirements
- R1: A store accepted after a barrier is never presented on the write port while any store accepted before that barrier is still unacknowledged.
- R2: Opcode bytes 0x0F 0xAE with a third byte 0xF0 to 0xF7 (full fence) also insert a barrier. A third byte 0xE8 to 0xEF (load fence) inserts none, and stores behind it issue while earlier stores are still pending.
- R3: Opcode bytes 0x0F 0xAE with a third byte 0xF8 to 0xFF insert a store barrier whatever the low three bits are, and raise no fault.
- R4: A fence encoding with `op_lock` high, or a store-fence encoding while `ext_en` is low, raises `op_fault` for one cycle, one cycle after the op is accepted. No barrier is inserted.
- R5: A store to the same word as the youngest entry merges into that entry when the entry has not been issued and is in the current epoch. The new bytes overwrite the old ones in the lanes it enables, and the byte enables are OR-ed. A store never merges across a barrier.
- R6: Stores issue in acceptance order, at most one per cycle. Each write carries the word address, data and byte enables of its entry.
- R7: The queue holds `DEPTH` entries. `st_ready` is low only when the queue is full and the offered store cannot merge into the youngest entry.
- R8: A load returns, one cycle later, the youngest buffered byte for each lane. `ld_hit` is high only when every requested lane is covered, so a partial match reads as a miss. Loads are served even while a barrier is pending.
- R9: `fence_drained` is high after reset. It is low while an unacknowledged store older than the latest barrier remains, and it returns high once that store is acknowledged.
- R10: `op_ready` drops when 2^`EPW`-1 epochs are open between the oldest buffered store and the newest barrier, and it rises again as the buffer drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | AW | 8-byte word address of the store |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| op_valid | input | 1 | Opcode bytes offered |
| op_ready | output | 1 | Room for another epoch |
| op_bytes | input | 24 | Opcode bytes, first byte in bits 23:16 |
| op_lock | input | 1 | Op carries a lock prefix |
| ext_en | input | 1 | Streaming extension enabled |
| op_fault | output | 1 | Invalid-opcode fault pulse |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | AW | Load word address |
| ld_be | input | DW/8 | Requested byte lanes |
| ld_rvalid | output | 1 | Lookup result valid |
| ld_hit | output | 1 | All requested lanes forwarded |
| ld_data | output | DW | Forwarded bytes |
| mem_wvalid | output | 1 | Write issued this cycle |
| mem_waddr | output | AW | Write word address |
| mem_wdata | output | DW | Write data |
| mem_wbe | output | DW/8 | Write byte enables |
| mem_ack | input | 1 | Acknowledge of the oldest outstanding write |
| fence_drained | output | 1 | No pending store is older than the latest barrier |

## Verification
The bench builds the block with its default sizes: eight entries and a 4-bit epoch tag. With these sizes a short run can fill the queue and then test a merge into a full queue. Fifteen back-to-back barriers are enough to exhaust the epoch window and watch `op_ready` fall and recover. The memory model's acknowledge delay and hold switch keep earlier stores outstanding for as long as needed. This lets the bench see whether later stores wait behind a barrier, pass a load fence, or merge while blocked.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  localparam logic [7:0] OPC_ESC = 8'h0F;
  localparam logic [7:0] OPC_GRP = 8'hAE;

  typedef enum logic [1:0] {
    FK_NONE  = 2'd0,
    FK_LOAD  = 2'd1,
    FK_FULL  = 2'd2,
    FK_STORE = 2'd3
  } fence_kind_e;
endpackage

// File: rtl/sbf_decode.sv
module sbf_decode
  import sbf_pkg::*;
(
  input  logic [23:0] op_bytes,
  input  logic        op_lock,
  input  logic        ext_en,
  output fence_kind_e kind,
  output logic        barrier,
  output logic        fault
);
  always_comb begin
    kind = FK_NONE;
    if (op_bytes[23:16] == OPC_ESC && op_bytes[15:8] == OPC_GRP) begin
      case (op_bytes[7:3])
        5'b11101: kind = FK_LOAD;
        5'b11110: kind = FK_FULL;
        5'b11111: kind = FK_STORE;
        default:  kind = FK_NONE;
      endcase
    end
    fault   = (kind != FK_NONE && op_lock) || (kind == FK_STORE && !ext_en);
    barrier = !fault && (kind == FK_FULL || kind == FK_STORE);
  end
endmodule

// File: rtl/sbf_forward.sv
module sbf_forward #(
  parameter int DEPTH = 8,
  parameter int AW    = 29,
  parameter int DW    = 64,
  parameter int PW    = 3,
  parameter int CW    = 4
) (
  input  logic [PW-1:0]   head,
  input  logic [CW-1:0]   count,
  input  logic [AW-1:0]   e_addr [DEPTH],
  input  logic [DW-1:0]   e_data [DEPTH],
  input  logic [DW/8-1:0] e_be   [DEPTH],
  input  logic [AW-1:0]   q_addr,
  input  logic [DW/8-1:0] q_be,
  output logic            hit,
  output logic [DW-1:0]   data
);
  localparam int BW = DW / 8;
  logic [BW-1:0] got;
  logic [PW-1:0] idx;

  // Oldest to youngest, so later (younger) entries overwrite lanes.
  always_comb begin
    got  = '0;
    data = '0;
    idx  = head;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PW'(k);
      if (CW'(k) < count && e_addr[idx] == q_addr) begin
        for (int b = 0; b < BW; b++) begin
          if (e_be[idx][b]) begin
            data[b*8 +: 8] = e_data[idx][b*8 +: 8];
            got[b]         = 1'b1;
          end
        end
      end
    end
    hit = (q_be != '0) && ((q_be & ~got) == '0);
  end
endmodule

// File: rtl/sbf_store_buffer.sv
module sbf_store_buffer
  import sbf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 29,
  parameter int DW    = 64,
  parameter int EPW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            st_valid,
  output logic            st_ready,
  input  logic [AW-1:0]   st_addr,
  input  logic [DW-1:0]   st_data,
  input  logic [DW/8-1:0] st_be,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [23:0]     op_bytes,
  input  logic            op_lock,
  input  logic            ext_en,
  output logic            op_fault,
  input  logic            ld_valid,
  input  logic [AW-1:0]   ld_addr,
  input  logic [DW/8-1:0] ld_be,
  output logic            ld_rvalid,
  output logic            ld_hit,
  output logic [DW-1:0]   ld_data,
  output logic            mem_wvalid,
  output logic [AW-1:0]   mem_waddr,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW/8-1:0] mem_wbe,
  input  logic            mem_ack,
  output logic            fence_drained
);
  localparam int BW   = DW / 8;
  localparam int PW   = $clog2(DEPTH);
  localparam int CW   = PW + 1;
  localparam int EMAX = (1 << EPW) - 1;

  logic [AW-1:0]  q_addr [DEPTH];
  logic [DW-1:0]  q_data [DEPTH];
  logic [BW-1:0]  q_be   [DEPTH];
  logic [EPW-1:0] q_ep   [DEPTH];

  logic [PW-1:0]  head;
  logic [CW-1:0]  count, iss_cnt;
  logic [EPW-1:0] tail_ep, ep_next, ref_ep, mem_wep;

  logic [PW-1:0]  tail_idx, young_idx, iss_idx;
  logic           issue_now, ack_ok, op_take, can_merge, take, do_merge, do_push;
  fence_kind_e    dec_kind;
  logic           dec_barrier, dec_fault, fwd_hit;
  logic [DW-1:0]  fwd_data;

  sbf_decode u_dec (
    .op_bytes (op_bytes),
    .op_lock  (op_lock),
    .ext_en   (ext_en),
    .kind     (dec_kind),
    .barrier  (dec_barrier),
    .fault    (dec_fault)
  );

  sbf_forward #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PW), .CW(CW)) u_fwd (
    .head   (head),
    .count  (count),
    .e_addr (q_addr),
    .e_data (q_data),
    .e_be   (q_be),
    .q_addr (ld_addr),
    .q_be   (ld_be),
    .hit    (fwd_hit),
    .data   (fwd_data)
  );

  always_comb begin
    tail_idx  = head + count[PW-1:0];
    young_idx = tail_idx - PW'(1);
    iss_idx   = head + iss_cnt[PW-1:0];
    // Next entry may go out if nothing is pending or it shares the oldest epoch.
    issue_now = (iss_cnt < count) && (iss_cnt == '0 || q_ep[iss_idx] == q_ep[head]);
    ack_ok    = mem_ack && (iss_cnt != '0);
    ref_ep    = (count != '0) ? q_ep[head] : tail_ep;
    op_ready  = (tail_ep - ref_ep) < EPW'(EMAX);
    op_take   = op_valid && op_ready;
    ep_next   = tail_ep + EPW'(op_take && dec_barrier);
    can_merge = (count > iss_cnt + CW'(issue_now)) && (q_ep[young_idx] == ep_next)
                && (q_addr[young_idx] == st_addr);
    st_ready  = (count != CW'(DEPTH)) || can_merge;
    take      = st_valid && st_ready;
    do_merge  = take && can_merge;
    do_push   = take && !can_merge;
  end

  // Entry storage: written at one port per cycle, no reset.
  always_ff @(posedge clk) begin
    if (do_push) begin
      q_addr[tail_idx] <= st_addr;
      q_data[tail_idx] <= st_data;
      q_be[tail_idx]   <= st_be;
      q_ep[tail_idx]   <= ep_next;
    end else if (do_merge) begin
      for (int b = 0; b < BW; b++)
        if (st_be[b]) q_data[young_idx][b*8 +: 8] <= st_data[b*8 +: 8];
      q_be[young_idx] <= q_be[young_idx] | st_be;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head          <= '0;
      count         <= '0;
      iss_cnt       <= '0;
      tail_ep       <= '0;
      mem_wvalid    <= 1'b0;
      mem_waddr     <= '0;
      mem_wdata     <= '0;
      mem_wbe       <= '0;
      mem_wep       <= '0;
      op_fault      <= 1'b0;
      ld_rvalid     <= 1'b0;
      ld_hit        <= 1'b0;
      ld_data       <= '0;
      fence_drained <= 1'b1;
    end else begin
      tail_ep    <= ep_next;
      head       <= head + PW'(ack_ok);
      count      <= count + CW'(do_push) - CW'(ack_ok);
      iss_cnt    <= iss_cnt + CW'(issue_now) - CW'(ack_ok);
      mem_wvalid <= issue_now;
      if (issue_now) begin
        mem_waddr <= q_addr[iss_idx];
        mem_wdata <= q_data[iss_idx];
        mem_wbe   <= q_be[iss_idx];
        mem_wep   <= q_ep[iss_idx];
      end
      op_fault      <= op_take && dec_fault;
      ld_rvalid     <= ld_valid;
      ld_hit        <= ld_valid && fwd_hit;
      ld_data       <= fwd_data;
      fence_drained <= (count == '0) || (q_ep[head] == tail_ep);
    end
  end
endmodule

// File: rtl/sbf_checker.sv
module sbf_checker #(
  parameter int DEPTH = 8,
  parameter int CW    = 4,
  parameter int EPW   = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           mem_wvalid,
  input logic           mem_ack,
  input logic [EPW-1:0] w_ep,
  input logic [EPW-1:0] tail_ep,
  input logic [CW-1:0]  count,
  input logic           st_ready,
  input logic           op_fault
);
  logic [CW:0]    out_cnt;
  logic [EPW-1:0] last_ep;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_cnt <= '0;
      last_ep <= '0;
    end else begin
      out_cnt <= out_cnt + (CW+1)'(mem_wvalid) - (CW+1)'(mem_ack && out_cnt != '0);
      if (mem_wvalid) last_ep <= w_ep;
    end
  end

  // R1: a write issued while others are pending belongs to their epoch
  a_r1_epoch_order: assert property (@(posedge clk) disable iff (rst)
    (mem_wvalid && out_cnt != '0) |-> (w_ep == last_ep));

  // R1: acknowledges only arrive for issued writes
  a_r1_ack_outstanding: assert property (@(posedge clk) disable iff (rst)
    mem_ack |-> (out_cnt != '0));

  // R7: never more than DEPTH entries
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R7: back-pressure only when full
  a_r7_ready_full: assert property (@(posedge clk) disable iff (rst)
    !st_ready |-> (count == CW'(DEPTH)));

  // R4: a faulted op opens no epoch
  a_r4_fault_no_epoch: assert property (@(posedge clk) disable iff (rst)
    op_fault |-> (tail_ep == $past(tail_ep)));
endmodule

bind sbf_store_buffer sbf_checker #(.DEPTH(DEPTH), .CW(CW), .EPW(EPW)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_wvalid (mem_wvalid),
  .mem_ack    (mem_ack),
  .w_ep       (mem_wep),
  .tail_ep    (tail_ep),
  .count      (count),
  .st_ready   (st_ready),
  .op_fault   (op_fault)
);

// File: tb/test_sbf_store_buffer.sv
module test_sbf_store_buffer;
  localparam int CLK_P = 10;

  logic        clk = 0, rst = 1;
  logic        st_valid = 0, st_ready;
  logic [28:0] st_addr = '0;
  logic [63:0] st_data = '0;
  logic [7:0]  st_be = '0;
  logic        op_valid = 0, op_ready, op_lock = 0, ext_en = 1, op_fault;
  logic [23:0] op_bytes = '0;
  logic        ld_valid = 0, ld_rvalid, ld_hit;
  logic [28:0] ld_addr = '0;
  logic [7:0]  ld_be = '0;
  logic [63:0] ld_data;
  logic        mem_wvalid, mem_ack = 0, fence_drained;
  logic [28:0] mem_waddr;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_wbe;

  sbf_store_buffer i_sbf_store_buffer (.*);

  always #(CLK_P/2) clk = ~clk;

  typedef struct { logic [28:0] a; logic [63:0] d; logic [7:0] b; int ep; } exp_t;
  exp_t exp_q[$];
  int   due_q[$];
  int   n_tests = 0, n_fail = 0, cyc = 0;
  int   b_ep = 0, o_cnt = 0, o_ep = 0, wr_total = 0, wr_busy = 0, ack_lat = 3;
  bit   ack_hold = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Monitor and memory model
  always @(negedge clk) begin
    mem_ack = 0;
    if (!rst && mem_wvalid) begin
      wr_total++;
      if (o_cnt > 0) wr_busy++;
      if (exp_q.size() == 0) chk(0, "R6 unexpected write", mem_waddr, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(mem_waddr == e.a && mem_wdata == e.d && mem_wbe == e.b, "R6 write content",
            {mem_wbe, mem_wdata[55:0]}, {e.b, e.d[55:0]});
        if (o_cnt > 0) chk(e.ep == o_ep, "R1 epoch order", e.ep, o_ep);
        o_cnt++;
        o_ep = e.ep;
        due_q.push_back(cyc + ack_lat);
      end
    end
    if (!rst && !ack_hold && due_q.size() > 0 && due_q[0] <= cyc) begin
      void'(due_q.pop_front());
      mem_ack = 1;
      o_cnt--;
    end
  end

  task automatic put_store(input logic [28:0] a, input logic [63:0] d, input logic [7:0] be, input bit merge);
    @(negedge clk);
    st_valid = 1; st_addr = a; st_data = d; st_be = be;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    st_valid = 0;
    if (merge && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q[exp_q.size()-1];
      for (int b = 0; b < 8; b++) if (be[b]) e.d[b*8 +: 8] = d[b*8 +: 8];
      e.b |= be;
      exp_q[exp_q.size()-1] = e;
    end else exp_q.push_back('{a, d, be, b_ep});
  endtask

  task automatic do_op(input logic [23:0] bytes, input bit lock, input bit barrier, output bit flt);
    @(negedge clk);
    op_valid = 1; op_bytes = bytes; op_lock = lock;
    #1;
    while (!op_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    op_valid = 0; op_lock = 0;
    if (barrier) b_ep++;
    @(negedge clk);
    flt = op_fault;
  endtask

  task automatic do_load(input logic [28:0] a, input logic [7:0] be, output bit h, output logic [63:0] d);
    @(negedge clk);
    ld_valid = 1; ld_addr = a; ld_be = be;
    @(negedge clk);
    ld_valid = 0;
    chk(ld_rvalid, "R8 load served", ld_rvalid, 1);
    h = ld_hit; d = ld_data;
  endtask

  task automatic drain();
    ack_hold = 0;
    while (exp_q.size() > 0 || o_cnt > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1;
    exp_q.delete(); due_q.delete();
    o_cnt = 0; b_ep = 0; ack_hold = 0;
    repeat (2) @(posedge clk);
    #1 rst = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    report();
  end

  initial begin
    bit f, h;
    logic [63:0] d;
    int w0;
    do_reset();
    @(negedge clk);
    chk(st_ready && op_ready && !mem_wvalid && !op_fault, "R7 reset ready/idle",
        {st_ready, op_ready, mem_wvalid, op_fault}, 4'b1100);
    chk(fence_drained, "R9 drained after reset", fence_drained, 1);

    // R6: plain stores drain in order
    for (int i = 0; i < 4; i++) put_store(29'h100 + i, 64'hA000 + i, 8'hFF, 0);
    drain();
    chk(exp_q.size() == 0, "R6 all writes seen", exp_q.size(), 0);

    // R1/R5: barrier holds later stores; merge inside epoch, not across barrier
    ack_lat = 20; wr_busy = 0; w0 = wr_total;
    put_store(29'h10, 64'h1111_1111_1111_1111, 8'hFF, 0);
    do_op(24'h0FAEF8, 0, 1, f);
    put_store(29'h20, 64'h0000_0000_2222_2222, 8'h0F, 0);
    put_store(29'h20, 64'h3333_3333_0000_0000, 8'hF0, 1);
    do_op(24'h0FAEF8, 0, 1, f);
    put_store(29'h20, 64'h0000_0000_4444_4444, 8'h0F, 0);
    drain();
    chk(wr_busy == 0, "R1 no write while earlier epoch pending", wr_busy, 0);
    chk(wr_total - w0 == 3, "R5 merge within epoch only", wr_total - w0, 3);

    // R2: load fence is no barrier
    wr_busy = 0;
    put_store(29'h30, 64'h55, 8'h01, 0);
    do_op(24'h0FAEE8, 0, 0, f);
    put_store(29'h31, 64'h66, 8'h01, 0);
    drain();
    chk(wr_busy >= 1, "R2 load fence lets stores pass", wr_busy, 1);

    // R3: low bits ignored; R9 drained status
    ack_hold = 1;
    put_store(29'h40, 64'h77, 8'h01, 0);
    do_op(24'h0FAEFB, 0, 1, f);
    chk(!f, "R3 no fault on store fence", f, 0);
    repeat (3) @(negedge clk);
    chk(!fence_drained, "R3 low bits ignored, barrier open", fence_drained, 0);
    drain();
    chk(fence_drained, "R9 drained after ack", fence_drained, 1);

    // R4: faults; R2 full fence
    ack_hold = 1;
    put_store(29'h50, 64'h88, 8'h01, 0);
    do_op(24'h0FAEF8, 1, 0, f);
    chk(f, "R4 lock prefix faults", f, 1);
    repeat (3) @(negedge clk);
    chk(fence_drained, "R4 faulted op inserts no barrier", fence_drained, 1);
    ext_en = 0;
    do_op(24'h0FAEFF, 0, 0, f);
    chk(f, "R4 extension disabled faults", f, 1);
    do_op(24'h0FAEF0, 0, 1, f);
    chk(!f, "R2 full fence legal without extension", f, 0);
    repeat (3) @(negedge clk);
    chk(!fence_drained, "R2 full fence is a barrier", fence_drained, 0);
    ext_en = 1;
    drain();

    // R7/R8: fill, back-pressure, merge into full queue, forwarding
    do_reset();
    ack_hold = 1;
    put_store(29'h0, 64'hF0, 8'hFF, 0);
    do_op(24'h0FAEF8, 0, 1, f);
    for (int i = 1; i < 7; i++) put_store(29'(i), 64'h0101_0101_0101_0101 * i, 8'hFF, 0);
    put_store(29'h7, 64'h0000_0000_0A0B_0C0D, 8'h0F, 0);
    @(negedge clk);
    st_valid = 1; st_addr = 29'h8; st_be = 8'hFF; #1;
    chk(!st_ready, "R7 full queue refuses new word", st_ready, 0);
    st_addr = 29'h7; #1;
    chk(st_ready, "R7 full queue accepts merge", st_ready, 1);
    st_valid = 0;
    put_store(29'h7, 64'h0000_EE00_0000_0000, 8'h30, 1);
    do_load(29'h3, 8'hFF, h, d);
    chk(h && d == 64'h0303_0303_0303_0303, "R8 full hit", d, 64'h0303_0303_0303_0303);
    do_load(29'h7, 8'hFF, h, d);
    chk(!h, "R8 partial match is miss", h, 0);
    do_load(29'h7, 8'h3F, h, d);
    chk(h && d[47:0] == 48'hEE00_0A0B_0C0D, "R8 youngest merged bytes", d, 64'hEE00_0A0B_0C0D);
    do_load(29'h9, 8'h01, h, d);
    chk(!h, "R8 no match is miss", h, 0);
    drain();

    // R10: epoch window limit
    ack_hold = 1;
    put_store(29'h60, 64'h1, 8'h01, 0);
    for (int i = 0; i < 14; i++) do_op(24'h0FAEF8, 0, 1, f);
    @(negedge clk); #1;
    chk(op_ready, "R10 ready below limit", op_ready, 1);
    do_op(24'h0FAEF8, 0, 1, f);
    #1;
    chk(!op_ready, "R10 window full", op_ready, 0);
    drain();
    #1;
    chk(op_ready, "R10 window reopens", op_ready, 1);
    chk(exp_q.size() == 0, "R6 scoreboard empty", exp_q.size(), 0);
    report();
  end
endmodule